// File: doc/BRIEF.md
# Layered Graph Node Feature Update

This block computes a fresh feature vector for every node of a layered hit graph. For each node it builds two edge-weighted neighbour sums. The first collects the features of the start nodes of the edges that end at this node, so it gathers from the previous layer. The second collects the features of the end nodes of the edges that start at this node, so it gathers from the next layer. Each neighbour's contribution is scaled by the score of the edge that joins it, as supplied by an upstream edge-scoring stage. The two sums and the node's own features form the input of a two-layer perceptron. Both layers use a tanh-shaped activation.

The node features, the two edge association matrices, the edge scores and all perceptron weights are presented as flat input vectors. They are held stable for the whole pass. A one-cycle `start_i` launches a pass. The block visits the nodes in order. For each node it spends one cycle per edge on aggregation, one cycle on the hidden layer and one cycle on the output layer. Results go to an output buffer that is separate from the input features, so every node of a pass is computed from the old features. `done_o` pulses once the last node has been written.

All values are signed fixed point with `W` bits and `F` fraction bits (default Q8.8). Products and sums are kept at full width. They are rounded and saturated back to `W` bits only where a result leaves an accumulator.

Top module: `nagg_node_update`

## Requirements
- R1: While `rst_ni` is low and after its release, `busy_o` and `done_o` are 0 and every bit of `x_new_o` is 0.
- R2: The previous-layer sum of node n, feature d, is P = sum over edges e with `dst_i[n*E+e]`=1 of score(e) times the sum over nodes m with `src_i[m*E+e]`=1 of x(m,d). Node m feature d sits at bits `[(m*D+d)*W +: W]` of `x_i`, and score e sits at `[e*W +: W]` of `score_i`. The aggregate fed onward is sat(rnd(P)).
- R3: The next-layer sum of node n is Q = sum over edges e with `src_i[n*E+e]`=1 of score(e) times the sum over nodes m with `dst_i[m*E+e]`=1 of x(m,d). The aggregate fed onward is sat(rnd(Q)).
- R4: The hidden-layer input vector has 3*D entries: entries 0..D-1 hold the previous-layer aggregates, D..2D-1 the next-layer aggregates, and 2D..3D-1 the node's own features. Hidden unit j equals act(sat(rnd(b1(j)*2^F + sum over k of w1(j,k)*in(k)))), where w1(j,k) sits at `w1_i[(j*3*D+k)*W +: W]` and b1(j) at `b1_i[j*W +: W]`.
- R5: rnd(a) = floor((a + 2^(F-1)) / 2^F). act(v) keeps the sign of v and maps a=|v| to a when a < 0.5, to 0.5 + floor((a-0.5)/2) when 0.5 <= a < 1.5, and to 1.0 otherwise. The thresholds are in Q(F).
- R6: Output feature d of node n equals act(sat(rnd(b2(d)*2^F + sum over j of w2(d,j)*h(j)))), where w2(d,j) sits at `w2_i[(d*H+j)*W +: W]`. It is written to `x_new_o[(n*D+d)*W +: W]`.
- R7: An association bit of 0 adds nothing. A node with no edges in one direction gets an all-zero aggregate for that direction, whatever the edge scores are.
- R8: `busy_o` is high from the cycle after the accepted start until the cycle in which `done_o` pulses. `done_o` is a one-cycle pulse that appears exactly N*(E+2) clock edges after the edge that accepted `start_i`.
- R9: A `start_i` pulse while `busy_o` is high is ignored: it changes neither the timing nor the results of the pass.
- R10: `x_new_o` changes only during a pass. After `done_o` it holds its values while the inputs change, until the next pass.
- R11: Every rounded sum saturates to the signed W-bit range, giving -2^(W-1) or 2^(W-1)-1, instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a pass when idle |
| x_i | input | N*D*W | Current node features |
| src_i | input | N*E | Bit n*E+e set when node n is the start of edge e |
| dst_i | input | N*E | Bit n*E+e set when node n is the end of edge e |
| score_i | input | E*W | Per-edge scores |
| w1_i | input | H*3*D*W | Hidden-layer weights |
| b1_i | input | H*W | Hidden-layer biases |
| w2_i | input | D*H*W | Output-layer weights |
| b2_i | input | D*W | Output-layer biases |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| x_new_o | output | N*D*W | Updated node features |

## Verification
The assertions assume that a pass begins only through `start_i`, and that the output buffer has no writer other than the pass itself. The properties on `done_o`, `busy_o` and `x_new_o` rest on these two assumptions. The bench drives `start_i` for one cycle at a time, and it changes features, scores and weights only while the block is idle. This keeps every pass inside the contract that the inputs stay stable. One scenario deliberately breaks that rule by changing the inputs after a pass, to show that the held results do not move. Another pulses `start_i` in the middle of a pass to show that the pulse is ignored.

// File: rtl/nagg_pkg.sv
package nagg_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_AGG, ST_HID, ST_OUT} nagg_state_e;

  // round half up, drop f fraction bits
  function automatic logic signed [63:0] q_round(input logic signed [63:0] a, input int unsigned f);
    return (a + (64'sd1 <<< (f - 1))) >>> f;
  endfunction

  function automatic logic signed [63:0] q_sat(input logic signed [63:0] a, input int unsigned w);
    logic signed [63:0] hi, lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (a > hi) return hi;
    if (a < lo) return lo;
    return a;
  endfunction

  // three-segment odd approximation of tanh
  function automatic logic signed [63:0] q_act(input logic signed [63:0] v, input int unsigned f);
    logic signed [63:0] half, knee, one, mag, r;
    half = 64'sd1 <<< (f - 1);
    knee = 64'sd3 <<< (f - 1);
    one  = 64'sd1 <<< f;
    mag  = (v < 0) ? -v : v;
    if (mag < half)      r = mag;
    else if (mag < knee) r = half + ((mag - half) >>> 1);
    else                 r = one;
    return (v < 0) ? -r : r;
  endfunction

endpackage

// File: rtl/nagg_edge_accum.sv
module nagg_edge_accum #(
  parameter int N    = 9,
  parameter int E    = 18,
  parameter int D    = 3,
  parameter int W    = 16,
  parameter int NW   = 4,
  parameter int EW   = 5,
  parameter int ACCW = 41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [EW-1:0]     eidx_i,
  input  logic [NW-1:0]     node_i,
  input  logic [N*D*W-1:0]  x_i,
  input  logic [N*E-1:0]    src_i,
  input  logic [N*E-1:0]    dst_i,
  input  logic [E*W-1:0]    score_i,
  output logic [D*ACCW-1:0] acc_prev_o,
  output logic [D*ACCW-1:0] acc_next_o
);
  localparam int GW = W + $clog2(N + 1);
  localparam int PW = W + GW;

  logic signed [GW-1:0]   src_feat [D];
  logic signed [GW-1:0]   dst_feat [D];
  logic signed [PW-1:0]   p_prev   [D];
  logic signed [PW-1:0]   p_next   [D];
  logic signed [ACCW-1:0] prev_q   [D];
  logic signed [ACCW-1:0] next_q   [D];
  logic signed [W-1:0]    sc;
  logic                   is_dst, is_src;

  assign sc     = $signed(score_i[int'(eidx_i)*W +: W]);
  assign is_dst = dst_i[int'(node_i)*E + int'(eidx_i)];
  assign is_src = src_i[int'(node_i)*E + int'(eidx_i)];

  // endpoint features of the current edge, summed over marked nodes
  always_comb begin
    for (int d = 0; d < D; d++) begin
      src_feat[d] = '0;
      dst_feat[d] = '0;
      for (int m = 0; m < N; m++) begin
        if (src_i[m*E + int'(eidx_i)])
          src_feat[d] = src_feat[d] + GW'($signed(x_i[(m*D+d)*W +: W]));
        if (dst_i[m*E + int'(eidx_i)])
          dst_feat[d] = dst_feat[d] + GW'($signed(x_i[(m*D+d)*W +: W]));
      end
      p_prev[d] = PW'(sc) * PW'(src_feat[d]);
      p_next[d] = PW'(sc) * PW'(dst_feat[d]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < D; d++) begin
        prev_q[d] <= '0;
        next_q[d] <= '0;
      end
    end else if (clr_i) begin
      for (int d = 0; d < D; d++) begin
        prev_q[d] <= '0;
        next_q[d] <= '0;
      end
    end else if (en_i) begin
      for (int d = 0; d < D; d++) begin
        if (is_dst) prev_q[d] <= prev_q[d] + ACCW'(p_prev[d]);
        if (is_src) next_q[d] <= next_q[d] + ACCW'(p_next[d]);
      end
    end
  end

  for (genvar d = 0; d < D; d++) begin : g_flat
    assign acc_prev_o[d*ACCW +: ACCW] = prev_q[d];
    assign acc_next_o[d*ACCW +: ACCW] = next_q[d];
  end

endmodule

// File: rtl/nagg_dense.sv
module nagg_dense
  import nagg_pkg::*;
#(
  parameter int NIN  = 9,
  parameter int NOUT = 8,
  parameter int W    = 16,
  parameter int F    = 8
) (
  input  logic [NIN*W-1:0]      in_i,
  input  logic [NOUT*NIN*W-1:0] wt_i,
  input  logic [NOUT*W-1:0]     b_i,
  output logic [NOUT*W-1:0]     out_o
);
  localparam int LACC = 2*W + $clog2(NIN + 2) + 1;

  for (genvar j = 0; j < NOUT; j++) begin : g_unit
    logic signed [LACC-1:0] sum;
    always_comb begin
      sum = LACC'($signed(b_i[j*W +: W])) <<< F;
      for (int k = 0; k < NIN; k++)
        sum = sum + LACC'($signed(in_i[k*W +: W])) * LACC'($signed(wt_i[(j*NIN+k)*W +: W]));
    end
    assign out_o[j*W +: W] = W'(q_act(q_sat(q_round(64'(sum), F), W), F));
  end

endmodule

// File: rtl/nagg_ctrl.sv
module nagg_ctrl
  import nagg_pkg::*;
#(
  parameter int N  = 9,
  parameter int E  = 18,
  parameter int NW = 4,
  parameter int EW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          clr_o,
  output logic          acc_en_o,
  output logic          hid_we_o,
  output logic          row_we_o,
  output logic [NW-1:0] node_o,
  output logic [EW-1:0] eidx_o,
  output logic          busy_o,
  output logic          done_o
);
  nagg_state_e   state_q;
  logic [NW-1:0] node_q;
  logic [EW-1:0] eidx_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      node_q  <= '0;
      eidx_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_AGG;
          node_q  <= '0;
          eidx_q  <= '0;
        end
        ST_AGG: begin
          if (eidx_q == EW'(E - 1)) state_q <= ST_HID;
          else                      eidx_q  <= eidx_q + 1'b1;
        end
        ST_HID: state_q <= ST_OUT;
        ST_OUT: begin
          if (node_q == NW'(N - 1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_AGG;
            node_q  <= node_q + 1'b1;
            eidx_q  <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign clr_o    = ((state_q == ST_IDLE) && start_i) || (state_q == ST_OUT);
  assign acc_en_o = (state_q == ST_AGG);
  assign hid_we_o = (state_q == ST_HID);
  assign row_we_o = (state_q == ST_OUT);
  assign node_o   = node_q;
  assign eidx_o   = eidx_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;

endmodule

// File: rtl/nagg_node_update.sv
module nagg_node_update
  import nagg_pkg::*;
#(
  parameter int N = 9,
  parameter int E = 18,
  parameter int D = 3,
  parameter int H = 8,
  parameter int W = 16,
  parameter int F = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [N*D*W-1:0]   x_i,
  input  logic [N*E-1:0]     src_i,
  input  logic [N*E-1:0]     dst_i,
  input  logic [E*W-1:0]     score_i,
  input  logic [H*3*D*W-1:0] w1_i,
  input  logic [H*W-1:0]     b1_i,
  input  logic [D*H*W-1:0]   w2_i,
  input  logic [D*W-1:0]     b2_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [N*D*W-1:0]   x_new_o
);
  localparam int NW   = (N > 1) ? $clog2(N) : 1;
  localparam int EW   = (E > 1) ? $clog2(E) : 1;
  localparam int ACCW = 2*W + $clog2(N + 1) + $clog2(E + 1);
  localparam int KI   = 3 * D;

  logic          clr, acc_en, hid_we, row_we;
  logic [NW-1:0] node;
  logic [EW-1:0] eidx;

  logic [D*ACCW-1:0] acc_prev, acc_next;
  logic [KI*W-1:0]   l1_in;
  logic [H*W-1:0]    hid_d, hid_q;
  logic [D*W-1:0]    row_d;
  logic [N*D*W-1:0]  xo_q;

  nagg_ctrl #(.N(N), .E(E), .NW(NW), .EW(EW)) ctrl_i (
    .clk_i, .rst_ni, .start_i,
    .clr_o(clr), .acc_en_o(acc_en), .hid_we_o(hid_we), .row_we_o(row_we),
    .node_o(node), .eidx_o(eidx), .busy_o, .done_o
  );

  nagg_edge_accum #(.N(N), .E(E), .D(D), .W(W), .NW(NW), .EW(EW), .ACCW(ACCW)) accum_i (
    .clk_i, .rst_ni, .clr_i(clr), .en_i(acc_en), .eidx_i(eidx), .node_i(node),
    .x_i, .src_i, .dst_i, .score_i,
    .acc_prev_o(acc_prev), .acc_next_o(acc_next)
  );

  // perceptron input: prev aggregate, next aggregate, own features
  for (genvar d = 0; d < D; d++) begin : g_in
    assign l1_in[d*W +: W] =
      W'(q_sat(q_round(64'($signed(acc_prev[d*ACCW +: ACCW])), F), W));
    assign l1_in[(D+d)*W +: W] =
      W'(q_sat(q_round(64'($signed(acc_next[d*ACCW +: ACCW])), F), W));
    assign l1_in[(2*D+d)*W +: W] = x_i[(int'(node)*D + d)*W +: W];
  end

  nagg_dense #(.NIN(KI), .NOUT(H), .W(W), .F(F)) hid_layer_i (
    .in_i(l1_in), .wt_i(w1_i), .b_i(b1_i), .out_o(hid_d)
  );

  nagg_dense #(.NIN(H), .NOUT(D), .W(W), .F(F)) out_layer_i (
    .in_i(hid_q), .wt_i(w2_i), .b_i(b2_i), .out_o(row_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hid_q <= '0;
    else if (hid_we) hid_q <= hid_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xo_q <= '0;
    end else if (row_we) begin
      for (int m = 0; m < N; m++)
        if (node == NW'(m)) xo_q[m*D*W +: D*W] <= row_d;
    end
  end

  assign x_new_o = xo_q;

endmodule

// File: rtl/nagg_checker.sv
module nagg_checker #(
  parameter int XW = 432
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [XW-1:0] x_new_o
);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_end_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_begin_on_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_o) |-> $stable(x_new_o));

endmodule

bind nagg_node_update nagg_checker #(.XW(N*D*W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .x_new_o(x_new_o)
);

// File: tb/nagg_node_update_tb.sv
module nagg_node_update_tb_top;
  localparam int N = 9, E = 18, D = 3, H = 8, W = 16, F = 8;
  localparam int KI = 3 * D;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = N * (E + 2);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [N*D*W-1:0]  x = '0;
  logic [N*E-1:0]    src = '0, dst = '0;
  logic [E*W-1:0]    score = '0;
  logic [H*KI*W-1:0] w1 = '0;
  logic [H*W-1:0]    b1 = '0;
  logic [D*H*W-1:0]  w2 = '0;
  logic [D*W-1:0]    b2 = '0;
  logic busy_o, done_o;
  logic [N*D*W-1:0] x_new;

  int checks = 0, bad = 0;
  int unsigned seed = 32'h1234_5678;
  longint exp_q [N][D];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nagg_node_update #(.N(N), .E(E), .D(D), .H(H), .W(W), .F(F)) dut_i (
    .clk_i, .rst_ni, .start_i, .x_i(x), .src_i(src), .dst_i(dst), .score_i(score),
    .w1_i(w1), .b1_i(b1), .w2_i(w2), .b2_i(b2),
    .busy_o, .done_o, .x_new_o(x_new)
  );

  // ---------------- reference arithmetic ----------------
  function automatic longint m_rnd(longint a);
    return (a + (64'sd1 <<< (F - 1))) >>> F;
  endfunction
  function automatic longint m_sat(longint a);
    longint hi = (64'sd1 <<< (W - 1)) - 1;
    if (a > hi) return hi;
    if (a < -hi - 1) return -hi - 1;
    return a;
  endfunction
  function automatic longint m_act(longint v);
    longint a = (v < 0) ? -v : v;
    longint r;
    if (a < 128) r = a;
    else if (a < 384) r = 128 + (a - 128) / 2;
    else r = 256;
    return (v < 0) ? -r : r;
  endfunction

  function automatic longint gx(int m, int d);
    return longint'($signed(x[(m*D+d)*W +: W]));
  endfunction
  function automatic longint gy(int m, int d);
    return longint'($signed(x_new[(m*D+d)*W +: W]));
  endfunction
  function automatic longint gs(int e);
    return longint'($signed(score[e*W +: W]));
  endfunction

  function automatic void model();
    for (int n = 0; n < N; n++) begin
      longint inv [KI];
      longint hid [H];
      for (int d = 0; d < D; d++) begin
        longint pa = 0, na = 0;
        for (int e = 0; e < E; e++) begin
          longint sf = 0, df = 0;
          for (int m = 0; m < N; m++) begin
            if (src[m*E+e]) sf += gx(m, d);
            if (dst[m*E+e]) df += gx(m, d);
          end
          if (dst[n*E+e]) pa += gs(e) * sf;
          if (src[n*E+e]) na += gs(e) * df;
        end
        inv[d] = m_sat(m_rnd(pa));
        inv[D+d] = m_sat(m_rnd(na));
        inv[2*D+d] = gx(n, d);
      end
      for (int j = 0; j < H; j++) begin
        longint s = longint'($signed(b1[j*W +: W])) * 256;
        for (int k = 0; k < KI; k++) s += longint'($signed(w1[(j*KI+k)*W +: W])) * inv[k];
        hid[j] = m_act(m_sat(m_rnd(s)));
      end
      for (int d = 0; d < D; d++) begin
        longint s = longint'($signed(b2[d*W +: W])) * 256;
        for (int j = 0; j < H; j++) s += longint'($signed(w2[(d*H+j)*W +: W])) * hid[j];
        exp_q[n][d] = m_act(m_sat(m_rnd(s)));
      end
    end
  endfunction

  // ---------------- stimulus helpers ----------------
  function automatic int rnd_val(int span);
    seed = seed * 1103515245 + 12345;
    return int'((seed >> 16) % (2*span + 1)) - span;
  endfunction

  task automatic set_x(int m, int d, longint v);  x[(m*D+d)*W +: W] = v[W-1:0]; endtask
  task automatic set_s(int e, longint v);         score[e*W +: W] = v[W-1:0]; endtask
  task automatic set_w1(int j, int k, longint v); w1[(j*KI+k)*W +: W] = v[W-1:0]; endtask
  task automatic set_w2(int d, int j, longint v); w2[(d*H+j)*W +: W] = v[W-1:0]; endtask

  task automatic clear_weights();
    w1 = '0; b1 = '0; w2 = '0; b2 = '0;
  endtask

  // 3 layers of 3 nodes, every node linked to every node of the next layer
  task automatic build_layered();
    src = '0; dst = '0;
    for (int e = 0; e < E; e++) begin
      int l = e / 9, a = (e % 9) / 3, b = e % 3;
      src[(l*3 + a)*E + e] = 1'b1;
      dst[((l+1)*3 + b)*E + e] = 1'b1;
    end
  endtask

  task automatic check_val(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_rows(string req);
    for (int m = 0; m < N; m++) begin
      int bad_d = -1;
      for (int d = 0; d < D; d++) if (bad_d < 0 && gy(m, d) != exp_q[m][d]) bad_d = d;
      checks++;
      if (bad_d >= 0) begin
        bad++;
        $display("FAIL %s node %0d feature %0d actual=%0d expected=%0d",
                 req, m, bad_d, gy(m, bad_d), exp_q[m][bad_d]);
      end
    end
  endtask

  task automatic run_pass(bit poke, string req);
    int cnt = 0;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    check_val("R8", "busy after start", longint'(busy_o), 1);
    while (cnt < 4*LAT) begin
      @(negedge clk_i);
      cnt++;
      start_i = poke && (cnt == 50);
      if (done_o) break;
    end
    start_i = 1'b0;
    check_val(req, "latency", cnt, LAT);
    check_val("R8", "busy at done", longint'(busy_o), 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check_val("R1", "busy", longint'(busy_o), 0);
    check_val("R1", "done", longint'(done_o), 0);
    check_val("R1", "x_new nonzero", longint'(x_new != '0), 0);
  endtask

  task automatic t_prev_only();
    build_layered(); clear_weights();
    for (int m = 0; m < N; m++) for (int d = 0; d < D; d++) set_x(m, d, (m*D+d)*8 - 40);
    for (int e = 0; e < E; e++) set_s(e, e*4 + 8);
    for (int d = 0; d < D; d++) begin set_w1(d, d, 256); set_w2(d, d, 256); end
    model();
    run_pass(1'b0, "R8");
    check_rows("R2");
    for (int d = 0; d < D; d++) check_val("R7", "first layer prev aggregate", gy(0, d), 0);
  endtask

  task automatic t_next_only();
    clear_weights();
    for (int d = 0; d < D; d++) begin set_w1(d, D+d, 256); set_w2(d, d, 256); end
    model();
    run_pass(1'b0, "R8");
    check_rows("R3");
    for (int d = 0; d < D; d++) check_val("R7", "last layer next aggregate", gy(8, d), 0);
  endtask

  task automatic t_mixed();
    build_layered();
    for (int m = 0; m < N; m++) for (int d = 0; d < D; d++) set_x(m, d, rnd_val(200));
    for (int e = 0; e < E; e++) set_s(e, rnd_val(160));
    for (int j = 0; j < H; j++) begin
      b1[j*W +: W] = 16'(rnd_val(64));
      for (int k = 0; k < KI; k++) set_w1(j, k, rnd_val(300));
    end
    for (int d = 0; d < D; d++) begin
      b2[d*W +: W] = 16'(rnd_val(64));
      for (int j = 0; j < H; j++) set_w2(d, j, rnd_val(300));
    end
    model();
    run_pass(1'b0, "R8");
    check_rows("R4");
    check_rows("R6");
  endtask

  task automatic t_act();
    clear_weights();
    for (int m = 0; m < N; m++) for (int d = 0; d < D; d++) set_x(m, d, m*40 - 160);
    for (int j = 0; j < H; j++) begin
      set_w1(j, 2*D, 256);
      b1[j*W +: W] = 16'(j*150 - 520);
      set_w2(0, j, 64);
      set_w2(1, j, (j % 2) ? 200 : -90);
    end
    set_w2(2, 3, 600);
    model();
    run_pass(1'b0, "R8");
    check_rows("R5");
  endtask

  task automatic t_no_edges();
    int cut [9] = '{0, 1, 2, 4, 7, 12, 13, 14, 1};
    build_layered(); clear_weights();
    for (int i = 0; i < 9; i++) for (int m = 0; m < N; m++) begin
      src[m*E + cut[i]] = 1'b0; dst[m*E + cut[i]] = 1'b0;
    end
    for (int e = 0; e < E; e++) set_s(e, 16'sh0800);
    for (int m = 0; m < N; m++) for (int d = 0; d < D; d++) set_x(m, d, rnd_val(100));
    for (int d = 0; d < D; d++) begin
      set_w1(d, d, 256); set_w1(D+d, D+d, 256);
      set_w2(d, d, 256); set_w2(d, D+d, 256);
    end
    model();
    run_pass(1'b0, "R8");
    check_rows("R7");
    for (int d = 0; d < D; d++) check_val("R7", "isolated node", gy(4, d), 0);
  endtask

  task automatic t_saturate();
    build_layered(); clear_weights();
    for (int m = 0; m < N; m++) for (int d = 0; d < D; d++) set_x(m, d, (d == 1) ? -25600 : 25600);
    for (int e = 0; e < E; e++) set_s(e, 1024);
    for (int d = 0; d < D; d++) begin set_w1(d, d, 256); set_w2(d, d, 256); end
    model();
    run_pass(1'b0, "R8");
    check_rows("R11");
    check_val("R11", "saturated positive", gy(3, 0), 192);
    check_val("R11", "saturated negative", gy(3, 1), -192);
    check_val("R5", "middle segment", gy(5, 2), 192);
  endtask

  task automatic t_busy_start();
    t_mixed_cfg();
    model();
    run_pass(1'b1, "R9");
    check_rows("R9");
    repeat (3) @(negedge clk_i);
    check_val("R9", "stays idle", longint'(busy_o), 0);
  endtask

  task automatic t_mixed_cfg();
    build_layered();
    for (int m = 0; m < N; m++) for (int d = 0; d < D; d++) set_x(m, d, rnd_val(150));
    for (int e = 0; e < E; e++) set_s(e, rnd_val(200));
  endtask

  task automatic t_hold();
    t_mixed_cfg();
    model();
    run_pass(1'b0, "R8");
    for (int m = 0; m < N; m++) for (int d = 0; d < D; d++) set_x(m, d, rnd_val(3000));
    for (int e = 0; e < E; e++) set_s(e, rnd_val(3000));
    repeat (25) @(negedge clk_i);
    check_rows("R10");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_prev_only();
    t_next_only();
    t_mixed();
    t_act();
    t_no_edges();
    t_saturate();
    t_busy_start();
    t_hold();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule